// File: doc/BRIEF.md
# Supervisory Reset Controller with Watchdog

This block produces the reset for a processor from three independent causes: a supply-good flag from an external voltage comparator, an active-low manual reset input, and a watchdog input that the running processor must toggle often enough. It drives two reset outputs with opposite polarity, so that loads of either sense can be served from one source. The clock and the controller's own reset come from an always-on domain. The watchdog input and the manual reset input may arrive asynchronously.

One reset-interval timer is shared by all causes. While any cause is active, the timer is reloaded. Reset is released only after a full interval during which no cause was seen. A supply drop forces the outputs at once through a combinational path, with no clock edge in between. A manual reset low pulse must last a minimum number of cycles before it counts, so that short switching noise is rejected. The watchdog restarts from zero after each edge, after each reset it caused, and each time it is re-enabled. A separate enable input tells the block whether the watchdog pin is being driven at all.

The timeouts are parameters in clock cycles. The defaults assume a 125 MHz clock. They give a reset interval of about 210 ms, a watchdog interval of about 1.76 s, and a glitch filter of about 100 ns. There is no data stream, so every pin is a plain level signal.

Top module: `svc_reset_supervisor`

## Requirements
- R1: While `supply_ok` is 0, `rst_out` is 1 and `rst_out_n` is 0 in the same cycle, with no clock edge needed.
- R2: When `supply_ok` returns to 1 and no other cause is active, the reset stays asserted and releases exactly `RST_CYCLES` rising clock edges after the first edge that sees `supply_ok` high.
- R3: A manual reset (`mr_n` low for at least `MR_FILT_CYCLES` cycles) holds reset for as long as `mr_n` stays low. After `mr_n` rises, reset releases `RST_CYCLES + 3` edges later: two synchronizer stages, one filter stage, then the interval.
- R4: An `mr_n` low pulse shorter than `MR_FILT_CYCLES` cycles has no effect on the outputs. A pulse of `MR_FILT_CYCLES` cycles or longer asserts reset.
- R5: Either edge of `wdi`, rising or falling, clears the watchdog timer. Toggling `wdi` with gaps shorter than `WD_CYCLES` keeps reset deasserted.
- R6: With `wd_en` high and no `wdi` edge, reset asserts `WD_CYCLES + 3` edges after the edge that first sees a `wdi` change. It is then held for exactly `RST_CYCLES` cycles.
- R7: After a watchdog reset releases, the watchdog timer starts again from zero. With no further edge, reset reasserts exactly `WD_CYCLES` edges after the release.
- R8: While `wd_en` is 0 the watchdog never causes a reset. After `wd_en` rises, with no `wdi` edge, reset asserts exactly `WD_CYCLES` edges later.
- R9: `rst_out_n` is always the complement of `rst_out`.
- R10: If causes overlap, reset releases only `RST_CYCLES` edges after the last cause has gone inactive.
- R11: While `rst_n` is low, reset is asserted. After `rst_n` rises, reset releases `RST_CYCLES` edges later. This is the power-on interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| supply_ok | input | 1 | Supply-good flag from the comparator; 0 means undervoltage |
| mr_n | input | 1 | Manual reset request, active low, asynchronous |
| wdi | input | 1 | Watchdog kick input, asynchronous; any edge counts |
| wd_en | input | 1 | 1 when the watchdog pin is driven, 0 disables the watchdog; synchronous to clk |
| rst_out_n | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |

## Verification
The assertions check the local rules on every cycle. These are the immediate effect of a supply drop, the opposite polarity of the two outputs, a timer reload on each active cause, release only after a quiet cycle, the watchdog counter being cleared by an edge, by reset or by a disable, and the filter dropping out when the manual input returns high. The bench's scenarios are needed for the end-to-end cycle counts: release latency after each cause, the watchdog firing time after an edge, after re-enable and after its own reset, the filter's pass and reject boundary, and overlap of several causes. Randomized kick gaps and short manual glitches show that legal traffic never produces a reset.

// File: rtl/svc_pkg.sv
`timescale 1ns/1ps
package svc_pkg;
  // Reset causes collected for the interval timer
  typedef struct packed {
    logic supply_low;
    logic manual;
    logic watchdog;
  } svc_cause_t;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/svc_sync.sv
`timescale 1ns/1ps
module svc_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= INIT;
          else        stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= INIT;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/svc_mr_filter.sv
`timescale 1ns/1ps
module svc_mr_filter #(
  parameter int MR_FILT_CYCLES = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mr_s_n,     // synchronized manual request, active low
  output logic mr_active
);
  localparam int FW = svc_pkg::cnt_width(MR_FILT_CYCLES);
  localparam logic [FW-1:0] FULL = FW'(MR_FILT_CYCLES);

  logic [FW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_cnt <= '0;
    else if (mr_s_n)       low_cnt <= '0;
    else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
  end

  assign mr_active = (low_cnt == FULL);

  // R4: a high level on the synchronized input drops the request next cycle
  a_r4_high_releases: assert property (@(posedge clk) disable iff (!rst_n)
    mr_s_n |=> !mr_active);
  // R4: the request can only start while the input is low
  a_r4_start_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mr_active) |-> $past(!mr_s_n));
endmodule

// File: rtl/svc_wd_timer.sv
`timescale 1ns/1ps
module svc_wd_timer #(
  parameter int WD_CYCLES = 220_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi_s,       // synchronized kick input
  input  logic wd_en,
  input  logic rst_active,  // reset currently driven to the processor
  output logic wd_fire
);
  localparam int WW = svc_pkg::cnt_width(WD_CYCLES);
  localparam logic [WW-1:0] LAST = WW'(WD_CYCLES - 1);

  logic          wdi_prev;
  logic          kick;
  logic [WW-1:0] wd_cnt;

  assign kick = wdi_s ^ wdi_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdi_prev <= 1'b0;
      wd_cnt   <= '0;
    end else begin
      wdi_prev <= wdi_s;
      if (!wd_en || rst_active || kick) wd_cnt <= '0;
      else if (wd_cnt != LAST)          wd_cnt <= wd_cnt + 1'b1;
    end
  end

  assign wd_fire = wd_en && !rst_active && !kick && (wd_cnt == LAST);

  // R5: any edge on the kick input restarts the count
  a_r5_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (wd_cnt == '0));
  // R7: the count is held at zero while reset is driven
  a_r7_hold_during_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_active |=> (wd_cnt == '0));
  // R8: a disabled watchdog restarts from zero
  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> (wd_cnt == '0));
endmodule

// File: rtl/svc_rst_timer.sv
`timescale 1ns/1ps
module svc_rst_timer #(
  parameter int RST_CYCLES = 26_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cause,
  output logic hold_q,
  output logic hold_n_q
);
  localparam int RW = svc_pkg::cnt_width(RST_CYCLES);
  localparam logic [RW-1:0] RELOAD = RW'(RST_CYCLES - 1);

  logic [RW-1:0] remain;
  logic          hold_d;
  logic [RW-1:0] remain_d;

  always_comb begin
    hold_d   = hold_q;
    remain_d = remain;
    if (cause) begin
      hold_d   = 1'b1;
      remain_d = RELOAD;
    end else if (hold_q) begin
      if (remain == '0) hold_d = 1'b0;
      else              remain_d = remain - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= 1'b1;
      hold_n_q <= 1'b0;
      remain   <= RELOAD;
    end else begin
      hold_q   <= hold_d;
      hold_n_q <= !hold_d;
      remain   <= remain_d;
    end
  end

  // R10: every active cause keeps or sets the hold
  a_r10_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> hold_q);
  // R10: release only follows a cycle with no active cause
  a_r10_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(!cause));
  // R2: the hold persists while time remains
  a_r2_interval_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && remain != '0) |=> hold_q);
endmodule

// File: rtl/svc_reset_supervisor.sv
`timescale 1ns/1ps
module svc_reset_supervisor #(
  parameter int RST_CYCLES     = 26_250_000,
  parameter int WD_CYCLES      = 220_000_000,
  parameter int MR_FILT_CYCLES = 13,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic mr_n,
  input  logic wdi,
  input  logic wd_en,
  output logic rst_out_n,
  output logic rst_out
);
  import svc_pkg::*;

  logic [1:0] raw_in;
  logic [1:0] sync_out;
  logic       mr_s_n;
  logic       wdi_s;
  logic       mr_active;
  logic       wd_fire;
  logic       hold_q;
  logic       hold_n_q;
  logic       rst_active;
  svc_cause_t causes;

  assign raw_in = {mr_n, wdi};

  svc_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );
  assign mr_s_n = sync_out[1];
  assign wdi_s  = sync_out[0];

  svc_mr_filter #(.MR_FILT_CYCLES(MR_FILT_CYCLES)) u_mr (
    .clk(clk), .rst_n(rst_n), .mr_s_n(mr_s_n), .mr_active(mr_active)
  );

  assign rst_active = hold_q || !supply_ok;

  svc_wd_timer #(.WD_CYCLES(WD_CYCLES)) u_wd (
    .clk(clk), .rst_n(rst_n), .wdi_s(wdi_s), .wd_en(wd_en),
    .rst_active(rst_active), .wd_fire(wd_fire)
  );

  always_comb begin
    causes.supply_low = !supply_ok;
    causes.manual     = mr_active;
    causes.watchdog   = wd_fire;
  end

  svc_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .cause(|causes),
    .hold_q(hold_q), .hold_n_q(hold_n_q)
  );

  // The supply path bypasses the clock so an undervoltage acts at once
  assign rst_out   = hold_q || !supply_ok;
  assign rst_out_n = hold_n_q && supply_ok;

  // R1: supply low forces both outputs in the same cycle
  a_r1_supply_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (rst_out && !rst_out_n));
  // R9: the two outputs never agree
  a_r9_complementary: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out_n != rst_out);
endmodule

// File: tb/svc_reset_supervisor_test.sv
`timescale 1ns/1ps
module svc_reset_supervisor_test;
  localparam int RST  = 40;
  localparam int WD   = 120;
  localparam int FILT = 6;

  logic clk = 1'b0;
  logic rst_n, supply_ok, mr_n, wdi, wd_en;
  logic rst_out_n, rst_out;
  int checks = 0;
  int failures = 0;
  int pol_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  svc_reset_supervisor #(
    .RST_CYCLES(RST), .WD_CYCLES(WD), .MR_FILT_CYCLES(FILT), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mr_n(mr_n),
    .wdi(wdi), .wd_en(wd_en), .rst_out_n(rst_out_n), .rst_out(rst_out)
  );

  // Expected latencies, in rising edges from the drive, taken from the requirements
  function automatic int exp_release(input string src);
    if (src == "manual") return RST + 3;
    return RST;
  endfunction
  function automatic int exp_fire(input string src);
    if (src == "kick") return WD + 3;
    return WD;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Counts rising edges until rst_out_n shows the given level at a falling edge
  task automatic edges_until(input logic level, output int n);
    n = 0;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (rst_out_n == level) break;
      if (n > 5000) begin n = 99999; break; end
    end
  endtask

  // Holds for n cycles, counting cycles where reset is seen
  task automatic quiet_for(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_out_n !== 1'b1) hits++;
    end
  endtask

  always @(negedge clk) if (rst_n && (rst_out_n === rst_out)) pol_err++;

  initial begin
    int n;
    int hits;
    void'($urandom(32'h5EED_0042));
    rst_n = 0; supply_ok = 1; mr_n = 1; wdi = 0; wd_en = 0;
    cycles(3);
    check(rst_out_n == 0 && rst_out == 1, "R11 held in reset", rst_out_n, 0);
    rst_n = 1;
    edges_until(1'b1, n);
    check(n == RST, "R11 power-on interval", n, RST);

    // Supply drop and return
    cycles(5);
    supply_ok = 0;
    #1;
    check(rst_out_n == 0 && rst_out == 1, "R1 immediate assert", rst_out_n, 0);
    cycles(10);
    check(rst_out_n == 0, "R1 held while low", rst_out_n, 0);
    supply_ok = 1;
    edges_until(1'b1, n);
    check(n == exp_release("supply"), "R2 supply release", n, exp_release("supply"));

    // Manual reset held and released
    cycles(5);
    mr_n = 0;
    cycles(30);
    check(rst_out_n == 0, "R3 held while mr_n low", rst_out_n, 0);
    mr_n = 1;
    edges_until(1'b1, n);
    check(n == exp_release("manual"), "R3 manual release", n, exp_release("manual"));

    // Filter boundaries
    cycles(5);
    mr_n = 0; cycles(FILT - 1); mr_n = 1;
    quiet_for(20, hits);
    check(hits == 0, "R4 short pulse ignored", hits, 0);
    mr_n = 0; cycles(FILT); mr_n = 1;
    edges_until(1'b0, n);
    check(n < 20, "R4 pulse at filter length asserts", n, FILT + 3);
    edges_until(1'b1, n);
    cycles(5);

    // Overlapping causes
    supply_ok = 0; mr_n = 0;
    cycles(10);
    supply_ok = 1;
    cycles(RST + 20);
    check(rst_out_n == 0, "R10 held by remaining cause", rst_out_n, 0);
    mr_n = 1;
    edges_until(1'b1, n);
    check(n == exp_release("manual"), "R10 release after last cause", n, exp_release("manual"));

    // Watchdog enable, fire, hold, restart
    cycles(5);
    wd_en = 1;
    edges_until(1'b0, n);
    check(n == exp_fire("enable"), "R8 fire after enable", n, exp_fire("enable"));
    edges_until(1'b1, n);
    check(n == RST, "R6 watchdog hold interval", n, RST);
    edges_until(1'b0, n);
    check(n == exp_fire("restart"), "R7 restart from zero", n, exp_fire("restart"));
    wd_en = 0;
    edges_until(1'b1, n);
    quiet_for(3 * WD, hits);
    check(hits == 0, "R8 disabled never fires", hits, 0);

    // Kick then starve
    wd_en = 1; wdi = ~wdi;
    edges_until(1'b0, n);
    check(n == exp_fire("kick"), "R6 fire after last kick", n, exp_fire("kick"));
    edges_until(1'b1, n);
    check(n == RST, "R6 hold after kick timeout", n, RST);

    // Random kicks and short manual glitches: no reset expected
    hits = 0;
    for (int it = 0; it < 60; it++) begin
      int gap;
      int h;
      gap = 1 + int'($urandom % (WD - 10));
      wdi = ~wdi;
      if ($urandom % 3 == 0 && gap > FILT + 4) begin
        int g;
        g = 1 + int'($urandom % (FILT - 1));
        mr_n = 0; quiet_for(g, h); hits += h;
        mr_n = 1; quiet_for(gap - g, h); hits += h;
      end else begin
        quiet_for(gap, h); hits += h;
      end
    end
    check(hits == 0, "R5 random kicks keep reset off", hits, 0);
    check(hits == 0, "R4 random short glitches ignored", hits, 0);
    wd_en = 0;
    cycles(5);

    check(pol_err == 0, "R9 outputs complementary", pol_err, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule